// File: doc/BRIEF.md
# Prescaled Receive Line Glitch Filter

This block cleans up a noisy asynchronous serial receive line, such as a single-wire bus input, before bit timing logic sees it. The raw line is first brought into the module clock domain by a two-flop synchronizer. A programmable divider then produces a filter tick once every 1 to 4 module clock cycles. On each tick, a saturating up/down integrator moves one step toward the synchronized level.

The cleaned output changes state only when the integrator reaches one of its ends. It goes high when the count reaches 16 and goes low when the count reaches 0. A level that is held for fewer than 16 ticks therefore cannot move the output, and such a pulse is discarded as noise. The filter delay scales with the divide ratio and in inverse proportion to the module clock frequency. At 8 MHz it spans 2, 4, 6 or 8 µs.

Software sets the divide ratio through one 8-bit register, using a write strobe and a read strobe. For every change of the cleaned output, the block also raises a one-cycle edge strobe together with a direction bit.

Top module: `rx_glitch_filter`

## Requirements
- R1: The divide code is held in bits 1:0 of the register. A write stores `reg_wdata[1:0]`. When `reg_rd` is high, `reg_rdata` presents the code in the following cycle; in every other cycle it is 0.
- R2: After reset the divide code is 2'b10, which selects divide-by-3.
- R3: Bits 7:2 of the register always read as 0, and writing them has no effect.
- R4: Code 00 gives one filter tick every clock cycle, 01 one every 2 cycles, 10 one every 3 and 11 one every 4. At divide-by-1, a level change that is held on `rx_raw` shows up on `rx_clean` 18 clock edges after it is applied.
- R5: A pulse on the synchronized input that lasts fewer than 16 ticks, starting from a saturated integrator, does not change `rx_clean`.
- R6: Reset leaves `rx_clean` high, the integrator full at 16, the synchronizer high and `edge_stb` low.
- R7: The integrator moves by exactly one step per tick, stays within 0..16, and keeps partial counts from one pulse to the next. It is not disturbed by a change of the divide code.
- R8: A write that changes the divide code restarts the divider count. A write of the value already held leaves the divider running.
- R9: `edge_stb` is high for exactly the one cycle in which `rx_clean` takes its new value. In that cycle `edge_rise` is 1 for a rising edge and 0 for a falling edge.
- R10: `rx_raw` passes through two synchronizer flops before it reaches the integrator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; drives the synchronizer, the divider and the integrator |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd` |
| rx_raw | input | 1 | Asynchronous raw receive line |
| rx_clean | output | 1 | Filtered receive level |
| edge_stb | output | 1 | One-cycle strobe on each change of `rx_clean` |
| edge_rise | output | 1 | Edge direction in the strobe cycle (1 rising, 0 falling) |

## Verification
The filter is driven with several kinds of input:
- Long held levels at divide-by-1, which pin the synchronizer and integrator latency to an exact edge count.
- A 15-tick pulse from a saturated count, which must be rejected.
- Two near-threshold pulses separated by a short gap, which pass only because partial counts carry over.
- A pseudo-random noise stream, including run lengths near the threshold, at all four divide codes with occasional code rewrites.

Alternating writes of differing codes must starve the divider of ticks, while repeated writes of the same code must not. This separates a restart on change from a restart on every write. A behavioural model tracks every output on every cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef logic [1:0] div_code_t;
  localparam div_code_t DIV_CODE_RESET = 2'b10;
  localparam int        DIV_CODE_W     = 2;
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output div_code_t         code,
  output logic              restart
);
  localparam int PAD_W = DATA_W - DIV_CODE_W;

  div_code_t code_q;
  div_code_t code_in;

  assign code_in = wdata[DIV_CODE_W-1:0];
  assign restart = wr && (code_in != code_q);
  assign code    = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= DIV_CODE_RESET;
      rdata  <= '0;
    end else begin
      if (wr) code_q <= code_in;
      rdata <= rd ? {{PAD_W{1'b0}}, code_q} : '0;
    end
  end
endmodule

// File: rtl/rxf_tick_gen.sv
module rxf_tick_gen
  import rxf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  div_code_t code,
  input  logic      restart,
  output logic      tick
);
  div_code_t cnt_q;

  assign tick = (cnt_q == code);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + div_code_t'(1);
  end
endmodule

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= RESET_VAL;
        else if (i == 0) chain_q[i] <= d;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rxf_integrator.sv
module rxf_integrator #(
  parameter int FILTER_TICKS = 16,
  parameter int CNT_W        = $clog2(FILTER_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             level,
  output logic [CNT_W-1:0] count,
  output logic             out,
  output logic             stb,
  output logic             rise
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FILTER_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             out_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (tick) begin
      if (level && (cnt_q != FULL))     cnt_nxt = cnt_q + CNT_W'(1);
      else if (!level && (cnt_q != '0)) cnt_nxt = cnt_q - CNT_W'(1);
    end
  end

  always_comb begin
    out_nxt = out;
    if (cnt_nxt == FULL)    out_nxt = 1'b1;
    else if (cnt_nxt == '0) out_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= FULL;
      out   <= 1'b1;
      stb   <= 1'b0;
      rise  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      out   <= out_nxt;
      stb   <= (out_nxt != out);
      rise  <= out_nxt;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/rx_glitch_filter.sv
module rx_glitch_filter
  import rxf_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int FILTER_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_raw,
  output logic              rx_clean,
  output logic              edge_stb,
  output logic              edge_rise
);
  localparam int CNT_W = $clog2(FILTER_TICKS + 1);

  div_code_t        code;
  logic             restart;
  logic             tick;
  logic             rx_sync;
  logic [CNT_W-1:0] integ_cnt;

  rxf_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
    .rdata(reg_rdata), .code(code), .restart(restart)
  );

  rxf_tick_gen u_tick (
    .clk(clk), .rst(rst), .code(code), .restart(restart), .tick(tick)
  );

  rxf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(rx_raw), .q(rx_sync)
  );

  rxf_integrator #(.FILTER_TICKS(FILTER_TICKS), .CNT_W(CNT_W)) u_integ (
    .clk(clk), .rst(rst), .tick(tick), .level(rx_sync), .count(integ_cnt),
    .out(rx_clean), .stb(edge_stb), .rise(edge_rise)
  );
endmodule

// File: rtl/rx_glitch_filter_chk.sv
module rx_glitch_filter_chk #(
  parameter int DATA_W       = 8,
  parameter int FILTER_TICKS = 16,
  parameter int CNT_W        = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              rx_clean,
  input logic              edge_stb,
  input logic              edge_rise,
  input logic              tick,
  input logic [CNT_W-1:0]  integ_cnt
);
  // R3: upper register bits never read back as 1
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:2] == '0);

  // R9: strobe marks exactly the cycles where the output changed
  p_stb_on_change_r9: assert property (@(posedge clk) disable iff (rst)
    edge_stb == (rx_clean != $past(rx_clean)));

  // R9: direction bit follows the new level
  p_rise_dir_r9: assert property (@(posedge clk) disable iff (rst)
    edge_stb |-> (edge_rise == rx_clean));

  // R9: strobe lasts a single cycle
  p_stb_single_r9: assert property (@(posedge clk) disable iff (rst)
    edge_stb |=> !edge_stb);

  // R4: the output only moves on an edge that consumed a tick
  p_move_needs_tick_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(rx_clean));

  // R7: integrator stays in range
  p_count_range_r7: assert property (@(posedge clk) disable iff (rst)
    integ_cnt <= CNT_W'(FILTER_TICKS));

  // R7: integrator moves by at most one step
  p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
    (integ_cnt != $past(integ_cnt)) |->
      (((integ_cnt - $past(integ_cnt)) == CNT_W'(1)) ||
       (($past(integ_cnt) - integ_cnt) == CNT_W'(1))));
endmodule

bind rx_glitch_filter rx_glitch_filter_chk #(
  .DATA_W(DATA_W), .FILTER_TICKS(FILTER_TICKS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_rdata(reg_rdata), .rx_clean(rx_clean),
  .edge_stb(edge_stb), .edge_rise(edge_rise), .tick(tick), .integ_cnt(integ_cnt)
);

// File: tb/sim_rx_glitch_filter.sv
`timescale 1ns/1ps
module sim_rx_glitch_filter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rx_raw = 1'b1;
  logic       rx_clean, edge_stb, edge_rise;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_glitch_filter u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_raw(rx_raw),
    .rx_clean(rx_clean), .edge_stb(edge_stb), .edge_rise(edge_rise)
  );

  // behavioural reference model
  int m_s1, m_s2, m_code, m_pcnt, m_integ, m_out, m_stb, m_rise, m_rdata;
  always @(posedge clk) begin
    int t, ni, no;
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_code = 2; m_pcnt = 0; m_integ = 16;
      m_out = 1; m_stb = 0; m_rise = 0; m_rdata = 0;
    end else begin
      t = (m_pcnt == m_code);
      ni = m_integ;
      if (t) ni = m_s2 ? ((ni < 16) ? ni + 1 : 16) : ((ni > 0) ? ni - 1 : 0);
      no = (ni == 16) ? 1 : (ni == 0) ? 0 : m_out;
      m_stb = (no != m_out);
      m_rise = no;
      m_out = no;
      m_integ = ni;
      if (reg_wr && (int'(reg_wdata[1:0]) != m_code)) m_pcnt = 0;
      else if (t) m_pcnt = 0;
      else m_pcnt = m_pcnt + 1;
      m_rdata = reg_rd ? m_code : 0;
      if (reg_wr) m_code = int'(reg_wdata[1:0]);
      m_s2 = m_s1;
      m_s1 = int'(rx_raw);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      cycles++;
      check("R9/R5 model rx_clean", int'(rx_clean), m_out);
      check("R9 model edge_stb", int'(edge_stb), m_stb);
      if (edge_stb) check("R9 model edge_rise", int'(edge_rise), m_rise);
      check("R1 model reg_rdata", int'(reg_rdata), m_rdata);
    end
  end

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_read(input string tag, input int exp);
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    check(tag, int'(reg_rdata), exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic latency(input logic lvl, input string tag);
    int n;
    @(negedge clk); rx_raw = lvl; n = 0;
    do begin @(negedge clk); n++; end while (rx_clean != lvl && n < 300);
    check(tag, n, 18);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    done = 1'b1;
    summary();
  end

  initial begin
    bit seen_low;
    logic [15:0] lfsr;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R6 reset state
    check("R6 rx_clean after reset", int'(rx_clean), 1);
    check("R6 edge_stb after reset", int'(edge_stb), 0);
    // R2 reset code
    do_read("R2 reset divide code", 2);
    // R3 upper bits ignored, R1 readback
    do_write(8'hFF);
    do_read("R3/R1 write FF reads 03", 3);
    do_write(8'hFC);
    do_read("R3/R1 write FC reads 00", 0);
    do_write(8'h01);
    do_read("R1 write 01 reads 01", 1);
    // R4/R10 exact latency at divide-by-1
    do_write(8'h00);
    latency(1'b0, "R4/R10 falling latency div1");
    idle(4);
    latency(1'b1, "R4/R10 rising latency div1");
    idle(4);
    // R5 15-tick pulse rejected at divide-by-4
    do_write(8'h03);
    idle(80);
    seen_low = 1'b0;
    @(negedge clk); rx_raw = 1'b0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (!rx_clean) seen_low = 1'b1; end
    rx_raw = 1'b1;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (!rx_clean) seen_low = 1'b1; end
    check("R5 15-tick low pulse rejected", int'(seen_low), 0);
    // R7 partial count retained: second pulse after short gap passes
    rx_raw = 1'b0;
    for (int i = 0; i < 64; i++) begin @(negedge clk); if (!rx_clean) seen_low = 1'b1; end
    check("R7 accumulated pulses pass", int'(seen_low), 1);
    rx_raw = 1'b1;
    idle(100);
    check("R7 recovered high", int'(rx_clean), 1);
    // R8 alternating differing codes starve the divider
    rx_raw = 1'b0;
    for (int i = 0; i < 40; i++) do_write((i % 2 == 0) ? 8'h02 : 8'h03);
    check("R8 differing writes restart divider", int'(rx_clean), 1);
    // R8 same-value writes do not restart
    for (int i = 0; i < 40; i++) do_write(8'h02);
    check("R8 same-value writes keep divider", int'(rx_clean), 0);
    rx_raw = 1'b1;
    idle(80);
    // R7/R9 noise at every divide code
    lfsr = 16'hACE1;
    for (int c = 0; c < 4; c++) begin
      do_write(8'(c));
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[3:0] == 4'h0) rx_raw = ~rx_raw;
        if (lfsr[11:0] == 12'h001) begin
          reg_wr = 1'b1; reg_wdata = {6'h15, lfsr[5:4]};
          @(negedge clk); reg_wr = 1'b0;
        end
      end
    end
    idle(10);
    done = 1'b1;
    summary();
  end
endmodule